// File: doc/BRIEF.md
# Module-Wide Four-Bank Selector With Mirroring

This block steers bank selection for a flash ROM module that occupies several 4K pages of a processor's instruction space. It watches the instruction bus and recognises four 10-bit bank-enable opcodes. It keeps one bank number that applies to every page of the module at once, so a bank switch made from one page takes effect on all the module's pages together.

Each page has a 2-bit image descriptor in a configuration table. A page can be empty, hold a single unswitched image, hold a two-bank image, or hold a four-bank image. For every fetch the block combines the descriptor with the live bank number and returns the stored image bank that the fetch must read. Images with fewer than four banks are mirrored into the unused bank slots. The host loads the configuration table. The image storage sits outside the block.

Top module: `bank_mirror_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the live bank is bank 1. A four-bank page then reports image bank code 0.
- R2: On a qualified fetch, opcode 0x100 selects bank 1, 0x180 selects bank 2, 0x140 selects bank 3 and 0x1C0 selects bank 4. The new bank applies from the cycle after the fetch.
- R3: One bank has effect across the whole module: a bank-enable fetched from any page of the module changes the image bank that every other page reports.
- R4: A page with descriptor 1 (single image) reports image bank code 0 for all four live banks.
- R5: A page with descriptor 2 (two-bank image) reports code 0 when the live bank is 1 or 3, and code 1 when it is 2 or 4.
- R6: A page with descriptor 3 (four-bank image) reports code N-1 when the live bank is N.
- R7: An opcode on the instruction input while `fetch_valid` is low leaves the live bank unchanged.
- R8: A bank-enable opcode fetched from a page below `FIRST_PAGE`, or from a page whose descriptor is 0 (empty), leaves the live bank unchanged.
- R9: `hit` is high exactly when the page is at or above `FIRST_PAGE` (default 0x4) and its descriptor is not 0. While `hit` is low, `img_bank` is 0.
- R10: Instruction values other than the four bank-enable opcodes never change the live bank. This includes near neighbours such as 0x101 and 0x1FC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Qualifies `fetch_addr` and `instr` for this cycle |
| fetch_addr | input | 16 | Fetch address. The top 4 bits give the page number |
| instr | input | 10 | Instruction word read at `fetch_addr` |
| cfg_table | input | 32 | Descriptor of page p at bits [2p+1:2p]: 0 empty, 1 single, 2 two-bank, 3 four-bank |
| hit | output | 1 | The addressed page belongs to the module and holds an image |
| img_bank | output | 2 | Stored image bank to read, coded as image bank minus one |

## Verification
The bench steps through all four opcodes and reads back all three descriptor kinds after each switch. A design that mapped the two-bank mirror wrongly would report code 0 for bank 2 or code 1 for bank 3. A design that kept a separate bank per page would fail the check that a switch made on page 0x8 shows up on pages 0x4 and 0xF. The bench also sends each opcode while the strobe is low, from a page outside the module and from an empty page. A decoder that is not gated would then move the bank. Near-miss encodings such as 0x101 and 0x1FC catch a decoder that looks at only some of the instruction bits.

// File: rtl/bank_mirror_pkg.sv
// Shared types and opcode constants for the module-wide bank selector.
package bank_mirror_pkg;
    // Per-page image descriptor, two bits per page in the configuration table.
    typedef enum logic [1:0] {
        IMG_EMPTY  = 2'd0,
        IMG_SINGLE = 2'd1,
        IMG_TWO    = 2'd2,
        IMG_FOUR   = 2'd3
    } img_kind_e;

    localparam int INSTR_W = 10;

    localparam logic [INSTR_W-1:0] OP_BANK1 = 10'h100;
    localparam logic [INSTR_W-1:0] OP_BANK2 = 10'h180;
    localparam logic [INSTR_W-1:0] OP_BANK3 = 10'h140;
    localparam logic [INSTR_W-1:0] OP_BANK4 = 10'h1C0;
endpackage

// File: rtl/bank_op_decode.sv
// Recognises the four bank-enable opcodes.
// Assumes: the full instruction word is compared, so near-miss codes give no match.
module bank_op_decode
    import bank_mirror_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               is_bank_op,
    output logic [1:0]         bank_sel
);
    // Map each opcode to the bank code (bank number minus one).
    always_comb begin
        is_bank_op = 1'b1;
        bank_sel   = 2'd0;
        unique case (instr)
            OP_BANK1: bank_sel = 2'd0;
            OP_BANK2: bank_sel = 2'd1;
            OP_BANK3: bank_sel = 2'd2;
            OP_BANK4: bank_sel = 2'd3;
            default:  is_bank_op = 1'b0;
        endcase
    end
endmodule

// File: rtl/page_desc_lookup.sv
// Selects the descriptor of the addressed page and tells whether that page
// belongs to the module.
// Assumes: the table packs two bits per page, with page 0 in the lowest bits.
module page_desc_lookup
    import bank_mirror_pkg::*;
#(
    parameter int PAGE_W     = 4,
    parameter int FIRST_PAGE = 4,
    localparam int NUM_PAGES = 1 << PAGE_W
) (
    input  logic [PAGE_W-1:0]      page,
    input  logic [2*NUM_PAGES-1:0] cfg_table,
    output img_kind_e              kind,
    output logic                   page_hit
);
    logic [1:0] desc_arr [NUM_PAGES];

    // Unpack the table into one descriptor per page.
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_unpack
        assign desc_arr[p] = cfg_table[2*p +: 2];
    end

    logic in_range;

    // Range test and descriptor selection for the current page.
    always_comb begin
        in_range = (int'(page) >= FIRST_PAGE);
        kind     = img_kind_e'(desc_arr[page]);
        page_hit = in_range && (kind != IMG_EMPTY);
    end
endmodule

// File: rtl/bank_mirror_map.sv
// Turns the live bank into a stored image bank, mirroring images that have
// fewer than four banks into the unused slots.
// Assumes: the caller masks the result when the page is empty.
module bank_mirror_map
    import bank_mirror_pkg::*;
(
    input  img_kind_e  kind,
    input  logic [1:0] live_bank,
    output logic [1:0] img_bank
);
    // Fold the live bank onto the number of banks in the image.
    always_comb begin
        unique case (kind)
            IMG_FOUR: img_bank = live_bank;
            IMG_TWO:  img_bank = {1'b0, live_bank[0]};
            default:  img_bank = 2'd0;
        endcase
    end
endmodule

// File: rtl/bank_mirror_ctrl.sv
// Module-wide bank controller. It holds one bank number for all pages,
// updates it from qualified bank-enable fetches and reports, for each
// fetch, which stored image bank to read.
// Assumes: instr is the word at fetch_addr in the same cycle; the
// configuration table is stable while fetches run.
module bank_mirror_ctrl
    import bank_mirror_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_W     = 4,
    parameter int FIRST_PAGE = 4,
    localparam int NUM_PAGES = 1 << PAGE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fetch_valid,
    input  logic [ADDR_W-1:0]      fetch_addr,
    input  logic [INSTR_W-1:0]     instr,
    input  logic [2*NUM_PAGES-1:0] cfg_table,
    output logic                   hit,
    output logic [1:0]             img_bank
);
    logic [PAGE_W-1:0] page;
    img_kind_e         kind;
    logic              page_hit;
    logic              is_bank_op;
    logic [1:0]        bank_sel;
    logic [1:0]        bank_q;
    logic [1:0]        mapped;

    assign page = fetch_addr[ADDR_W-1 -: PAGE_W];

    bank_op_decode u_dec (
        .instr      (instr),
        .is_bank_op (is_bank_op),
        .bank_sel   (bank_sel)
    );

    page_desc_lookup #(
        .PAGE_W     (PAGE_W),
        .FIRST_PAGE (FIRST_PAGE)
    ) u_lookup (
        .page      (page),
        .cfg_table (cfg_table),
        .kind      (kind),
        .page_hit  (page_hit)
    );

    bank_mirror_map u_map (
        .kind      (kind),
        .live_bank (bank_q),
        .img_bank  (mapped)
    );

    // Single bank register shared by all pages; loaded by qualified opcodes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= 2'd0;
        else if (fetch_valid && page_hit && is_bank_op)
            bank_q <= bank_sel;
    end

    // Output drive: image bank only for pages that hold an image.
    always_comb begin
        hit      = page_hit;
        img_bank = page_hit ? mapped : 2'd0;
    end

    // R7
    bank_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(bank_q));

    // R8
    bank_hold_foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !hit) |=> $stable(bank_q));

    // R2
    bank_load_b2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && hit && instr == OP_BANK2) |=> (bank_q == 2'd1));

    // R10
    bank_hold_nonop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !is_bank_op) |=> $stable(bank_q));

    // R4
    single_img_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == IMG_SINGLE) |-> (img_bank == 2'd0));

    // R5
    two_img_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == IMG_TWO) |-> (img_bank[1] == 1'b0));

    // R9
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (img_bank == 2'd0));
endmodule

// File: tb/bank_mirror_ctrl_tb.sv
module bank_mirror_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic [9:0]  instr = '0;
    logic [31:0] cfg_table;
    logic        hit;
    logic [1:0]  img_bank;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bank_mirror_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .instr(instr), .cfg_table(cfg_table),
        .hit(hit), .img_bank(img_bank)
    );

    // Descriptor per page: 0 empty, 1 single, 2 two-bank, 3 four-bank
    function automatic logic [1:0] desc_of(input int p);
        case (p)
            5, 9:    return 2'd2;
            6:       return 2'd1;
            7:       return 2'd0;
            default: return 2'd3;
        endcase
    endfunction

    initial for (int p = 0; p < 16; p++) cfg_table[2*p +: 2] = desc_of(p);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fetch(input int page, input logic [9:0] op, input logic v);
        @(negedge clk);
        fetch_valid = v;
        fetch_addr  = {page[3:0], 12'h0A5};
        instr       = op;
        @(negedge clk);
        fetch_valid = 1'b0;
        instr       = '0;
    endtask

    // Probe with no strobe; outputs are combinational from the address.
    task automatic probe(input int page, input string tag, input int exp_img);
        fetch_valid = 1'b0;
        fetch_addr  = {page[3:0], 12'h123};
        #1;
        check(tag, int'(img_bank), exp_img);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        probe(4, "R1 four-bank page after reset", 0);
        probe(5, "R1 two-bank page after reset", 0);
    endtask

    task automatic t_opcodes();
        logic [9:0] ops [4] = '{10'h100, 10'h180, 10'h140, 10'h1C0};
        for (int b = 3; b >= 0; b--) begin
            fetch(8, ops[b], 1'b1);
            probe(8, "R2 R6 opcode selects bank", b);
            probe(4, "R3 R6 other page follows", b);
            probe(15, "R3 top page follows", b);
            probe(5, "R5 two-bank mirror", b & 1);
            probe(6, "R4 single image", 0);
        end
        fetch(12, ops[1], 1'b1);
        probe(9, "R5 two-bank bank2", 1);
        probe(4, "R2 bank2 from page 0xC", 1);
    endtask

    task automatic t_ignored();
        // live bank is 2 (code 1) here
        fetch(8, 10'h140, 1'b0);
        probe(4, "R7 no strobe", 1);
        fetch(2, 10'h1C0, 1'b1);
        probe(4, "R8 foreign page", 1);
        fetch(7, 10'h100, 1'b1);
        probe(4, "R8 empty page", 1);
        fetch(4, 10'h101, 1'b1);
        probe(4, "R10 near miss 0x101", 1);
        fetch(4, 10'h1FC, 1'b1);
        probe(4, "R10 near miss 0x1FC", 1);
        fetch(4, 10'h000, 1'b1);
        probe(4, "R10 zero word", 1);
    endtask

    task automatic t_hit();
        for (int p = 0; p < 16; p++) begin
            int exp_hit = (p >= 4 && desc_of(p) != 2'd0) ? 1 : 0;
            probe(p, "R9 img zero off module", exp_hit ? ((desc_of(p) == 2'd1) ? 0 : 1) : 0);
            check("R9 hit", int'(hit), exp_hit);
        end
    endtask

    task automatic t_rereset();
        fetch(10, 10'h1C0, 1'b1);
        probe(4, "R2 bank4 before reset", 3);
        t_reset();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_opcodes();
        t_ignored();
        t_hit();
        t_rereset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule